// File: doc/BRIEF.md
# Indirect PHY Register Access Master

This block gives a user port access to 16-bit PHY configuration registers that sit outside the memory map. The PHY side sees only one 32-bit control word, which the block drives, and one 32-bit status word, which the block reads. The status word carries an acknowledge flag and the 16-bit read data. Each access is a series of strobes. The block raises a strobe, waits until the acknowledge goes high, lowers the strobe, then waits until the acknowledge goes low again. It moves to the next step only when that last wait is over.

On the user side there is a plain request port. The caller presents an address, write data and a direction, and the request is taken on a clock edge where both valid and ready are high. When the access ends, the block pulses a done flag for one cycle. Read data and an error flag are valid with that pulse. Acknowledge polls are spaced a parameterised number of cycles apart, and each wait allows a bounded number of polls. If a wait runs out of polls, the block returns the control word to zero and reports an error.

States, in the order used: `ST_IDLE` waits for a request. `ST_ADDR_SET` puts the address on the field. `ST_ADDR_CAP` adds the address-capture strobe and waits for ack high. `ST_ADDR_REL` drops the strobe and waits for ack low. A write then goes `ST_DATA_SET` → `ST_DATA_CAP` (wait high) → `ST_DATA_REL` (wait low) → `ST_WR_STB` (wait high) → `ST_WR_REL` (wait low). A read goes `ST_RD_STB` (wait high, latch data) → `ST_RD_REL` (control cleared, wait low). Both paths end in `ST_FIN`, which drives the control word to zero, pulses done and returns to `ST_IDLE`. Any wait state whose last poll fails jumps straight to `ST_FIN` with the error set.

Top module: `phy_ctl_master`

## Requirements
- R1: The control word carries the address or data field in bits 15:0, address capture in bit 16, data capture in bit 17, write strobe in bit 18 and read strobe in bit 19. Bits 31:20 are always zero, and at most one of bits 19:16 is set at any time.
- R2: The acknowledge is taken from status bit 16 through a synchroniser, and read data is taken from status bits 15:0.
- R3: After a request is taken, the field first holds the address. The address capture strobe is then added and held until ack is seen high, and the field keeps the address while the strobe is down and the block waits for ack low. No strobe rises while ack is still high.
- R4: A write captures the data with the data capture strobe, using the same raise, ack high, lower, ack low cycle. It then raises the write strobe alone and completes the same cycle, and the access ends with the control word at zero. The value then reads back from the PHY.
- R5: A read raises the read strobe alone, waits for ack high and latches status bits 15:0. It then clears the control word and waits for ack low. The latched value appears on `rsp_rdata` with the done pulse.
- R6: Polls fall every `POLL_GAP` cycles, and one wait allows at most `MAX_TRIES` polls. If the address capture ack never rises, done and the error flag appear exactly 1+MAX_TRIES·POLL_GAP cycles after the accepting edge, with the control word at zero.
- R7: If ack is stuck high, the address capture wait succeeds on its first poll and the release wait times out. Done and the error flag then appear exactly 1+(MAX_TRIES+1)·POLL_GAP cycles after the accepting edge.
- R8: Ready is high only while the block is idle. A request presented while ready is low is ignored and causes no PHY access.
- R9: In the cycle after done, ready is high and the control word is zero. The error flag is high only with done.
- R10: After reset, ready is high, the control word is zero, and done and error are low.
- R11: An acknowledge that arrives late but within the poll budget completes the access without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_err | output | 1 | Poll budget exhausted (valid with done) |
| rsp_rdata | output | 16 | Read data (valid with done of a read) |
| ctl_word | output | 32 | Control word to the PHY access port |
| stat_word | input | 32 | Status word from the PHY access port |

## Verification
The bench models the PHY slave with an adjustable acknowledge latency. It counts falling edges from the accepting edge up to the done pulse.

Timeouts have a fixed latency, so the bench checks them on an exact cycle. An unanswered address capture must finish 1+MAX_TRIES·POLL_GAP cycles after acceptance. A stuck-high ack must finish one poll window later. Successful accesses depend on the latency, so for those the bench checks the result only when done arrives.

The bench samples `rsp_rdata`, `rsp_err` and `ctl_word` in the done cycle, and `req_ready` one cycle later. It drives all inputs and samples all outputs on falling edges, so that every registered output has settled.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

    localparam int FIELD_W      = 16;
    localparam int CTL_W        = 32;
    localparam int CAP_ADDR_BIT = 16;
    localparam int CAP_DATA_BIT = 17;
    localparam int WR_BIT       = 18;
    localparam int RD_BIT       = 19;
    localparam int ACK_BIT      = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_SET,
        ST_ADDR_CAP,
        ST_ADDR_REL,
        ST_DATA_SET,
        ST_DATA_CAP,
        ST_DATA_REL,
        ST_WR_STB,
        ST_WR_REL,
        ST_RD_STB,
        ST_RD_REL,
        ST_FIN
    } xfer_state_e;

endpackage

// File: rtl/phy_ack_sync.sv
module phy_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
    parameter int POLL_GAP  = 4,
    parameter int MAX_TRIES = 10,
    parameter int TRY_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    output logic             poll_evt,
    output logic             last_try,
    output logic [TRY_W-1:0] try_cnt
);
    localparam int GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] try_q;

    assign poll_evt = run && (gap_q == GAP_W'(POLL_GAP - 1));
    assign last_try = (try_q == TRY_W'(MAX_TRIES - 1));
    assign try_cnt  = try_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            try_q <= '0;
        end else if (clr || !run) begin
            gap_q <= '0;
            try_q <= '0;
        end else if (poll_evt) begin
            gap_q <= '0;
            if (!last_try) begin
                try_q <= try_q + 1'b1;
            end
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/phy_ctl_encode.sv
module phy_ctl_encode
    import phy_ctl_pkg::*;
(
    input  xfer_state_e        state,
    input  logic [FIELD_W-1:0] addr,
    input  logic [FIELD_W-1:0] data,
    output logic [CTL_W-1:0]   ctl,
    output logic               wait_en,
    output logic               expect_ack
);
    always_comb begin
        ctl        = '0;
        wait_en    = 1'b0;
        expect_ack = 1'b0;
        unique case (state)
            ST_IDLE, ST_FIN: begin
                ctl = '0;
            end
            ST_ADDR_SET: begin
                ctl[FIELD_W-1:0] = addr;
            end
            ST_ADDR_CAP: begin
                ctl[FIELD_W-1:0]  = addr;
                ctl[CAP_ADDR_BIT] = 1'b1;
                wait_en           = 1'b1;
                expect_ack        = 1'b1;
            end
            ST_ADDR_REL: begin
                ctl[FIELD_W-1:0] = addr;
                wait_en          = 1'b1;
            end
            ST_DATA_SET: begin
                ctl[FIELD_W-1:0] = data;
            end
            ST_DATA_CAP: begin
                ctl[FIELD_W-1:0]  = data;
                ctl[CAP_DATA_BIT] = 1'b1;
                wait_en           = 1'b1;
                expect_ack        = 1'b1;
            end
            ST_DATA_REL: begin
                ctl[FIELD_W-1:0] = data;
                wait_en          = 1'b1;
            end
            ST_WR_STB: begin
                ctl[WR_BIT] = 1'b1;
                wait_en     = 1'b1;
                expect_ack  = 1'b1;
            end
            ST_WR_REL: begin
                ctl[FIELD_W-1:0] = data;
                wait_en          = 1'b1;
            end
            ST_RD_STB: begin
                ctl[RD_BIT] = 1'b1;
                wait_en     = 1'b1;
                expect_ack  = 1'b1;
            end
            ST_RD_REL: begin
                wait_en = 1'b1;
            end
            default: begin
                ctl = '0;
            end
        endcase
    end
endmodule

// File: rtl/phy_ctl_master.sv
module phy_ctl_master
    import phy_ctl_pkg::*;
#(
    parameter int POLL_GAP    = 4,
    parameter int MAX_TRIES   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_done,
    output logic        rsp_err,
    output logic [15:0] rsp_rdata,
    output logic [31:0] ctl_word,
    input  logic [31:0] stat_word
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    xfer_state_e        state_q, state_d;
    logic [FIELD_W-1:0] addr_q, data_q, rdata_q;
    logic               write_q, err_q;
    logic               ack_s, wait_en, expect_ack;
    logic               poll_evt, last_try, step;
    logic               poll_hit, poll_timeout;
    logic [TRY_W-1:0]   try_cnt;
    logic [CTL_W-1:0]   ctl_enc;

    phy_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (stat_word[ACK_BIT]),
        .dout (ack_s)
    );

    phy_ctl_encode u_enc (
        .state     (state_q),
        .addr      (addr_q),
        .data      (data_q),
        .ctl       (ctl_enc),
        .wait_en   (wait_en),
        .expect_ack(expect_ack)
    );

    phy_poll_timer #(
        .POLL_GAP (POLL_GAP),
        .MAX_TRIES(MAX_TRIES),
        .TRY_W    (TRY_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (step),
        .run     (wait_en),
        .poll_evt(poll_evt),
        .last_try(last_try),
        .try_cnt (try_cnt)
    );

    assign poll_hit     = poll_evt && (ack_s == expect_ack);
    assign poll_timeout = poll_evt && (ack_s != expect_ack) && last_try;
    assign step         = (state_d != state_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_ADDR_SET;
            ST_ADDR_SET: state_d = ST_ADDR_CAP;
            ST_ADDR_CAP: if (poll_hit) state_d = ST_ADDR_REL;
            ST_ADDR_REL: if (poll_hit) state_d = write_q ? ST_DATA_SET : ST_RD_STB;
            ST_DATA_SET: state_d = ST_DATA_CAP;
            ST_DATA_CAP: if (poll_hit) state_d = ST_DATA_REL;
            ST_DATA_REL: if (poll_hit) state_d = ST_WR_STB;
            ST_WR_STB:   if (poll_hit) state_d = ST_WR_REL;
            ST_WR_REL:   if (poll_hit) state_d = ST_FIN;
            ST_RD_STB:   if (poll_hit) state_d = ST_RD_REL;
            ST_RD_REL:   if (poll_hit) state_d = ST_FIN;
            ST_FIN:      state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (wait_en && poll_timeout) begin
            state_d = ST_FIN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            write_q <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                data_q  <= req_wdata;
                write_q <= req_write;
                err_q   <= 1'b0;
            end
            if (state_q == ST_RD_STB && poll_hit) begin
                rdata_q <= stat_word[FIELD_W-1:0];
            end
            if (wait_en && poll_timeout) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctl_word  = ctl_enc;
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_FIN);
        rsp_err   = (state_q == ST_FIN) && err_q;
        rsp_rdata = rdata_q;
    end
endmodule

// File: rtl/phy_ctl_master_chk.sv
module phy_ctl_master_chk #(
    parameter int MAX_TRIES = 10,
    parameter int TRY_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [15:0]      req_addr,
    input logic [31:0]      ctl_word,
    input logic             rsp_done,
    input logic             rsp_err,
    input logic [TRY_W-1:0] try_cnt
);
    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_word[19:16]));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ctl_word == 32'h0));

    // R3
    accept_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && ctl_word[15:0] == $past(req_addr)));

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (req_ready && ctl_word == 32'h0));

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R6
    try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(try_cnt) < MAX_TRIES);
endmodule

bind phy_ctl_master phy_ctl_master_chk #(
    .MAX_TRIES(MAX_TRIES),
    .TRY_W    (TRY_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .ctl_word (ctl_word),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .try_cnt  (try_cnt)
);

// File: tb/phy_ctl_master_bench.sv
module phy_ctl_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 4;
    localparam int TRIES      = 10;
    localparam int NVEC       = 8;
    // {write, latency[7:0], addr[15:0], data[15:0]}
    localparam logic [40:0] VEC [0:NVEC-1] = '{
        {1'b1, 8'd1,  16'h0012, 16'hBEEF},
        {1'b0, 8'd1,  16'h0012, 16'h0000},
        {1'b0, 8'd3,  16'h0031, 16'h0000},
        {1'b1, 8'd0,  16'h00FF, 16'h0001},
        {1'b1, 8'd5,  16'h0100, 16'hFFFF},
        {1'b0, 8'd2,  16'h00FF, 16'h0000},
        {1'b0, 8'd6,  16'h0100, 16'h0000},
        {1'b1, 8'd25, 16'h0047, 16'h5A5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic [31:0] ctl_word, stat_word;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit wd_hit = 1'b0;

    // PHY slave model
    int          sl_lat = 1;
    bit          sl_mute = 1'b0;
    bit          sl_stuck = 1'b0;
    logic        ack_q;
    logic [15:0] rd_q, sl_addr, sl_data;
    logic [15:0] sl_mem [0:255];
    logic [15:0] shadow [0:255];
    int          lat_cnt;
    int          viol = 0;
    logic        strobe_w;
    logic        strobe_prev;

    assign strobe_w  = |ctl_word[19:16];
    assign stat_word = {15'b0, ack_q, rd_q};

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_ctl_master #(.POLL_GAP(GAP), .MAX_TRIES(TRIES), .SYNC_STAGES(2)) u_phy_ctl_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ctl_word(ctl_word), .stat_word(stat_word)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0; rd_q <= '0; sl_addr <= '0; sl_data <= '0;
            lat_cnt <= 0; strobe_prev <= 1'b0;
            for (int i = 0; i < 256; i++) sl_mem[i] <= 16'hA000 ^ 16'(i);
        end else begin
            strobe_prev <= strobe_w;
            // R3/R1: no strobe may rise while ack still high, no upper bits, one strobe
            if (strobe_w && !strobe_prev && ack_q && !sl_stuck) viol <= viol + 1;
            if (ctl_word[31:20] != 0 || $countones(ctl_word[19:16]) > 1) viol <= viol + 1;
            if (sl_stuck) ack_q <= 1'b1;
            else if (sl_mute) ack_q <= 1'b0;
            else if (strobe_w != ack_q) begin
                if (lat_cnt >= sl_lat) begin
                    lat_cnt <= 0;
                    ack_q <= strobe_w;
                    if (strobe_w) begin
                        if (ctl_word[16]) sl_addr <= ctl_word[15:0];
                        if (ctl_word[17]) sl_data <= ctl_word[15:0];
                        if (ctl_word[18]) sl_mem[sl_addr[7:0]] <= sl_data;
                        if (ctl_word[19]) rd_q <= sl_mem[sl_addr[7:0]];
                    end
                end else lat_cnt <= lat_cnt + 1;
            end else lat_cnt <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output bit er, output int k);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        k = 0;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            if (rsp_done) break;
            k++;
        end
        rd = rsp_rdata; er = rsp_err;
        // R9: control word zero in done cycle, ready in the next
        check(ctl_word == 0, "R9 ctl zero at done", ctl_word, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready after done", {31'b0, req_ready}, 1);
    endtask

    initial begin
        logic [15:0] rd;
        bit er;
        int k;
        for (int i = 0; i < 256; i++) shadow[i] = 16'hA000 ^ 16'(i);
        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready && !rsp_done && !rsp_err && ctl_word == 0, "R10 reset state",
              {req_ready, rsp_done, rsp_err, ctl_word[28:0]}, {3'b100, 29'h0});
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && ctl_word == 0, "R10 idle after reset", ctl_word, 0);

        // Vector walk: R2 R3 R4 R5 R11
        for (int v = 0; v < NVEC; v++) begin
            sl_lat = int'(VEC[v][39:32]);
            access(VEC[v][40], VEC[v][31:16], VEC[v][15:0], rd, er, k);
            check(er == 1'b0, "R11 no error on answered access", {31'b0, er}, 0);
            if (VEC[v][40]) shadow[VEC[v][23:16]] = VEC[v][15:0];
            else check(rd == shadow[VEC[v][23:16]], "R5 read data", {16'h0, rd},
                       {16'h0, shadow[VEC[v][23:16]]});
        end
        // R4 late-ack write must have landed
        sl_lat = 1;
        access(1'b0, 16'h0047, 16'h0, rd, er, k);
        check(rd == 16'h5A5A && !er, "R4 write read-back", {16'h0, rd}, 32'h5A5A);

        // R8: request while busy is ignored
        fork
            access(1'b1, 16'h0020, 16'h0F0F, rd, er, k);
            begin
                repeat (4) @(negedge clk);
                req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0055; req_wdata = 16'h1234;
                repeat (4) @(negedge clk);
                req_valid = 1'b0;
            end
        join
        shadow[8'h20] = 16'h0F0F;
        access(1'b0, 16'h0055, 16'h0, rd, er, k);
        check(rd == shadow[8'h55], "R8 busy request ignored", {16'h0, rd}, {16'h0, shadow[8'h55]});

        // R6: no acknowledge at all
        sl_mute = 1'b1;
        access(1'b1, 16'h0060, 16'h7777, rd, er, k);
        check(er == 1'b1, "R6 timeout error", {31'b0, er}, 1);
        check(k == 1 + TRIES*GAP, "R6 timeout latency", k, 1 + TRIES*GAP);
        sl_mute = 1'b0;
        repeat (4) @(negedge clk);
        access(1'b0, 16'h0060, 16'h0, rd, er, k);
        check(rd == shadow[8'h60] && !er, "R6 aborted write not applied", {16'h0, rd}, {16'h0, shadow[8'h60]});

        // R7: ack stuck high
        sl_stuck = 1'b1;
        repeat (4) @(negedge clk);
        access(1'b0, 16'h0010, 16'h0, rd, er, k);
        check(er == 1'b1, "R7 stuck ack error", {31'b0, er}, 1);
        check(k == 1 + (TRIES+1)*GAP, "R7 stuck ack latency", k, 1 + (TRIES+1)*GAP);
        sl_stuck = 1'b0;
        repeat (6) @(negedge clk);

        // R2/R5 recovery read after error
        access(1'b0, 16'h0012, 16'h0, rd, er, k);
        check(rd == 16'hBEEF && !er, "R2 read after recovery", {16'h0, rd}, 32'hBEEF);

        // R1/R3 protocol monitor
        check(viol == 0, "R1 R3 protocol monitor", viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !wd_hit) begin
            wd_hit = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule